// File: doc/BRIEF.md
# Quad-mode serial pseudo-static RAM controller

This block drives a serial pseudo-static RAM from a simple host request port. After reset it holds the memory bus idle for a programmable settling interval. It then sends the switch-to-quad opcode one bit per serial clock on lane 0. From then on every command, address and data phase moves four bits per serial clock.

The host asks for one byte at a time. It presents a 24-bit byte address, a direction flag and, for writes, a data byte, and pulses `req_start` while `busy` is low. The controller frames the transfer with chip select, sends an opcode nibble pair and six address nibbles, and then does one of two things. For a write it sends the data byte as two nibbles. For a read it releases the lanes for four turnaround clocks and then samples two nibbles. It ends with `done` once chip select has gone high again.

The serial clock is the system clock divided by `2*HALF_DIV`. Each serial clock period starts with its low half, so the data lanes change only while the serial clock is low.

The state machine has these states:
- `ST_BOOT`: the settling wait after reset.
- `ST_MODE`: the eight single-bit beats of the quad-enable opcode.
- `ST_IDLE`: waiting for a request.
- `ST_OPC`: the opcode nibbles.
- `ST_ADR`: the address nibbles.
- `ST_GAP`: the read turnaround beats.
- `ST_WR`: the write data nibbles.
- `ST_RD`: the read data nibbles.
- `ST_FIN`: chip select high with `done` raised.

It makes these transitions:
- `ST_BOOT`→`ST_MODE` when the timer expires.
- `ST_MODE`→`ST_IDLE` after beat 7.
- `ST_IDLE`→`ST_OPC` on an accepted start.
- `ST_OPC`→`ST_ADR` after 2 beats.
- `ST_ADR`→`ST_WR` for a write, or `ST_ADR`→`ST_GAP` for a read, after 6 beats.
- `ST_GAP`→`ST_RD` after 4 beats.
- `ST_WR`/`ST_RD`→`ST_FIN` after 2 beats.
- `ST_FIN`→`ST_IDLE` after one cycle.

Top module: `qpsram_ctrl`

## Requirements
- R1: While reset is held, `mem_cs_n` is 1, `mem_sclk` is 0, `mem_dq_oe` is 0, `done` is 0 and `busy` is 1.
- R2: After reset is released, chip select stays high and the serial clock stays low for at least `BOOT_CYCLES` system clocks.
- R3: The mode-entry sequence is exactly 8 beats in one chip-select frame. Lane 0 (bit 0 of `mem_dq_out`) carries 0x35 MSB first, lanes 1 to 3 are driven 0, and `mem_dq_oe` is 4'b1111 on every beat.
- R4: A write is a 10-beat frame made of three parts, all with `mem_dq_oe` = 4'b1111:
  - opcode 0x02 as two nibbles, high nibble first;
  - the 24-bit address as six nibbles, most significant nibble first;
  - the data byte, high nibble first.
- R5: A read is a 14-beat frame made of four parts:
  - opcode 0x0B as two nibbles and then the address as six nibbles, all with `mem_dq_oe` = 4'b1111;
  - four turnaround beats with `mem_dq_oe` = 0;
  - two data beats with `mem_dq_oe` = 0;
  - `mem_dq_in` is sampled at the end of each data beat's high half, and `rd_data` = {first nibble, second nibble}.
- R6: Every serial clock period inside a frame lasts `2*HALF_DIV` system clocks. `mem_dq_out` and `mem_dq_oe` do not change while `mem_sclk` is high.
- R7: `mem_sclk` is high only while `mem_cs_n` is low, and chip select stays low from the first beat of a frame to its last.
- R8: `done` is a single-cycle pulse raised in the cycle in which `mem_cs_n` has returned high. `rd_data` holds the read byte at that point.
- R9: `busy` is high from the accepted start until `done`, and also during power-up. A `req_start` seen while `busy` is high starts no frame and does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| req_start | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write data byte |
| busy | output | 1 | Controller not ready for a new request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_sclk | output | 1 | Serial clock to the memory |
| mem_dq_out | output | 4 | Values driven on the four data lanes |
| mem_dq_oe | output | 4 | Per-lane output enable, 1 = drive |
| mem_dq_in | input | 4 | Values sampled from the four data lanes |

## Verification
Writes and reads are driven with the all-zero and all-one addresses and data, and with alternating and mixed nibble patterns. These patterns separate nibble-order and nibble-position errors in the opcode, address and data phases. Read data comes from a bench memory model keyed on the decoded address, so a wrong turnaround length or a sample taken in the wrong half of the clock gives a mismatched byte. Stray start strobes are issued during power-up and during both kinds of frame. A frame started by one of them, or a changed address, shows up as an unexpected or corrupted frame in the scoreboard.

// File: rtl/qpsram_pkg.sv
package qpsram_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_MODE,
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_GAP,
        ST_WR,
        ST_RD,
        ST_FIN
    } qp_state_t;

    localparam logic [7:0] OP_ENTER_QUAD = 8'h35;
    localparam logic [7:0] OP_READ       = 8'h0B;
    localparam logic [7:0] OP_WRITE      = 8'h02;

    localparam int BEAT_W = 3;

endpackage

// File: rtl/qpsram_boot_timer.sv
module qpsram_boot_timer #(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic rst,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != CW'(CYCLES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == CW'(CYCLES));
endmodule

// File: rtl/qpsram_pacer.sv
module qpsram_pacer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic beat_end
);
    localparam int PER = 2 * HALF_DIV;
    localparam int PW  = (PER > 1) ? $clog2(PER) : 1;

    logic [PW-1:0] ph;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ph <= '0;
        end else if (!run || ph == PW'(PER - 1)) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assign sclk     = run && (ph >= PW'(HALF_DIV));
    assign beat_end = run && (ph == PW'(PER - 1));
endmodule

// File: rtl/qpsram_ctrl.sv
module qpsram_ctrl
    import qpsram_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int BOOT_CYCLES = 40000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_start,
    input  logic        req_write,
    input  logic [23:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rd_data,
    output logic        mem_cs_n,
    output logic        mem_sclk,
    output logic [3:0]  mem_dq_out,
    output logic [3:0]  mem_dq_oe,
    input  logic [3:0]  mem_dq_in
);
    qp_state_t         st, st_nx;
    logic [BEAT_W-1:0] nb;
    logic [BEAT_W-1:0] nb_last;
    logic              run, sclk_i, beat_end, boot_done, last_beat;
    logic [23:0]       lat_addr;
    logic [7:0]        lat_wdata;
    logic              lat_we;
    logic [7:0]        rshift;
    logic [7:0]        opcode;
    logic [23:0]       addr_sh;

    qpsram_boot_timer #(.CYCLES(BOOT_CYCLES)) u_boot (
        .clk     (clk),
        .rst     (rst),
        .expired (boot_done)
    );

    qpsram_pacer #(.HALF_DIV(HALF_DIV)) u_pace (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sclk     (sclk_i),
        .beat_end (beat_end)
    );

    assign run = (st == ST_MODE) || (st == ST_OPC) || (st == ST_ADR) ||
                 (st == ST_GAP)  || (st == ST_WR)  || (st == ST_RD);

    always_comb begin
        unique case (st)
            ST_MODE: nb_last = 3'd7;
            ST_ADR:  nb_last = 3'd5;
            ST_GAP:  nb_last = 3'd3;
            default: nb_last = 3'd1;
        endcase
    end

    assign last_beat = beat_end && (nb == nb_last);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_BOOT: if (boot_done) st_nx = ST_MODE;
            ST_MODE: if (last_beat) st_nx = ST_IDLE;
            ST_IDLE: if (req_start) st_nx = ST_OPC;
            ST_OPC:  if (last_beat) st_nx = ST_ADR;
            ST_ADR:  if (last_beat) st_nx = lat_we ? ST_WR : ST_GAP;
            ST_GAP:  if (last_beat) st_nx = ST_RD;
            ST_WR:   if (last_beat) st_nx = ST_FIN;
            ST_RD:   if (last_beat) st_nx = ST_FIN;
            ST_FIN:  st_nx = ST_IDLE;
            default: st_nx = ST_BOOT;
        endcase
    end

    // state register, beat counter, request latch and read capture
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st        <= ST_BOOT;
            nb        <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_we    <= 1'b0;
            rshift    <= '0;
        end else begin
            st <= st_nx;
            if (st != st_nx) begin
                nb <= '0;
            end else if (beat_end) begin
                nb <= nb + 1'b1;
            end
            if (st == ST_IDLE && req_start) begin
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
                lat_we    <= req_write;
            end
            if (st == ST_RD && beat_end) begin
                rshift <= {rshift[3:0], mem_dq_in};
            end
        end
    end

    assign opcode  = lat_we ? OP_WRITE : OP_READ;
    assign addr_sh = lat_addr >> (5'd20 - {nb, 2'b00});

    // output decode
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_dq_oe  = 4'b0000;
        mem_dq_out = 4'b0000;
        done       = 1'b0;
        unique case (st)
            ST_MODE: begin
                mem_cs_n   = 1'b0;
                mem_dq_oe  = 4'b1111;
                mem_dq_out = {3'b000, OP_ENTER_QUAD[3'd7 - nb]};
            end
            ST_OPC: begin
                mem_cs_n   = 1'b0;
                mem_dq_oe  = 4'b1111;
                mem_dq_out = (nb == 3'd0) ? opcode[7:4] : opcode[3:0];
            end
            ST_ADR: begin
                mem_cs_n   = 1'b0;
                mem_dq_oe  = 4'b1111;
                mem_dq_out = addr_sh[3:0];
            end
            ST_WR: begin
                mem_cs_n   = 1'b0;
                mem_dq_oe  = 4'b1111;
                mem_dq_out = (nb == 3'd0) ? lat_wdata[7:4] : lat_wdata[3:0];
            end
            ST_GAP, ST_RD: begin
                mem_cs_n = 1'b0;
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
                mem_cs_n = 1'b1;
            end
        endcase
    end

    assign busy     = (st != ST_IDLE);
    assign rd_data  = rshift;
    assign mem_sclk = sclk_i;

    // R2: memory bus quiet until the settling interval has elapsed
    a_r2_quiet_boot: assert property (@(posedge clk) disable iff (rst)
        !boot_done |-> (mem_cs_n && !mem_sclk));

    // R7: serial clock only inside a chip-select frame
    a_r7_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        mem_sclk |-> !mem_cs_n);

    // R6: lanes steady across the high half of the serial clock
    a_r6_lanes_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_sclk && $past(mem_sclk)) |-> ($stable(mem_dq_out) && $stable(mem_dq_oe)));

    // R8: done lasts one cycle and comes with chip select high
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_cs_high: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_cs_n && !mem_sclk && busy));

    // R9: a strobe during a busy period leaves the latched request alone
    a_r9_no_relatch: assert property (@(posedge clk) disable iff (rst)
        (busy && req_start) |=> ($stable(lat_addr) && $stable(lat_we)));
endmodule

// File: tb/tb_qpsram_ctrl.sv
`timescale 1ns/1ps
module tb_qpsram_ctrl;
    localparam int HALF = 2;
    localparam int BOOT = 50;
    localparam real TCK = 5.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, mem_cs_n, mem_sclk;
    logic [7:0]  rd_data;
    logic [3:0]  mem_dq_out, mem_dq_oe;
    logic [3:0]  mem_dq_in = 4'h0;

    qpsram_ctrl #(.HALF_DIV(HALF), .BOOT_CYCLES(BOOT)) dut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_sclk(mem_sclk),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit          we;
        logic [23:0] a;
        logic [7:0]  d;
    } item_t;
    item_t exp_q[$];

    int checks = 0, errors = 0;
    int period_bad = 0, stable_bad = 0, idle_bad = 0, frames = 0, pushed = 0;
    bit init_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    // bus monitor
    logic [3:0] nib [0:15];
    logic [3:0] oeb [0:15];
    int bc = 0;
    realtime last_rise = 0;
    logic [7:0] hi_val = '0;

    function automatic logic [23:0] frame_addr();
        return {nib[2], nib[3], nib[4], nib[5], nib[6], nib[7]};
    endfunction

    always @(negedge mem_cs_n) bc = 0;

    always @(posedge mem_sclk) begin
        if (bc > 0 && ($realtime - last_rise) != 2 * HALF * TCK) period_bad++;
        last_rise = $realtime;
        if (bc < 16) begin
            nib[bc] = mem_dq_out;
            oeb[bc] = mem_dq_oe;
        end
        hi_val = {mem_dq_oe, mem_dq_out};
        bc++;
    end

    // memory model drives read nibbles shortly after the falling edge
    always @(negedge mem_sclk) begin
        #1;
        if (!mem_cs_n && bc == 12) mem_dq_in = model(frame_addr()) >> 4;
        else if (!mem_cs_n && bc == 13) mem_dq_in = model(frame_addr()) & 8'h0F;
    end

    always @(negedge clk) begin
        if (!rst && mem_sclk && ({mem_dq_oe, mem_dq_out} != hi_val)) stable_bad++;
        if (!rst && mem_cs_n && mem_sclk) idle_bad++;
    end

    // scoreboard: compare each finished frame with the queued item
    always @(posedge mem_cs_n) begin
        if (bc > 0) begin
            if (!init_seen) begin
                logic [7:0] l0;
                bit side_ok;
                init_seen = 1;
                side_ok = 1;
                l0 = '0;
                for (int i = 0; i < 8; i++) begin
                    l0 = {l0[6:0], nib[i][0]};
                    if (nib[i][3:1] != 3'b000 || oeb[i] != 4'hF) side_ok = 0;
                end
                chk(bc == 8, "R3", "mode beats", bc, 8);
                chk(l0 == 8'h35, "R3", "lane0 opcode", l0, 8'h35);
                chk(side_ok, "R3", "other lanes low, oe set", side_ok, 1);
            end else begin
                frames++;
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected frame", frame_addr(), 0);
                end else begin
                    item_t e;
                    logic [7:0] op;
                    bit oe_ok;
                    e = exp_q.pop_front();
                    op = e.we ? 8'h02 : 8'h0B;
                    oe_ok = 1;
                    if (e.we) begin
                        for (int i = 0; i < 10; i++) if (oeb[i] != 4'hF) oe_ok = 0;
                        chk(bc == 10, "R4", "write beats", bc, 10);
                        chk({nib[0], nib[1]} == op, "R4", "write opcode", {nib[0], nib[1]}, op);
                        chk(frame_addr() == e.a, "R4", "write address", frame_addr(), e.a);
                        chk({nib[8], nib[9]} == e.d, "R4", "write data", {nib[8], nib[9]}, e.d);
                        chk(oe_ok, "R4", "write oe", oe_ok, 1);
                    end else begin
                        for (int i = 0; i < 8; i++) if (oeb[i] != 4'hF) oe_ok = 0;
                        for (int i = 8; i < 14; i++) if (oeb[i] != 4'h0) oe_ok = 0;
                        chk(bc == 14, "R5", "read beats", bc, 14);
                        chk({nib[0], nib[1]} == op, "R5", "read opcode", {nib[0], nib[1]}, op);
                        chk(frame_addr() == e.a, "R5", "read address", frame_addr(), e.a);
                        chk(oe_ok, "R5", "read oe / turnaround", oe_ok, 1);
                    end
                end
            end
        end
    end

    // driver
    task automatic xfer(input bit we, input logic [23:0] a, input logic [7:0] d,
                        input bit stray);
        item_t it;
        int guard;
        while (busy) @(negedge clk);
        it.we = we; it.a = a; it.d = d;
        exp_q.push_back(it);
        pushed++;
        req_write = we; req_addr = a; req_wdata = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        if (stray) begin
            repeat (7) @(negedge clk);
            req_write = ~we; req_addr = ~a; req_wdata = ~d; req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 1000) begin
            if (!busy) begin
                chk(0, "R9", "busy dropped before done", busy, 1);
                break;
            end
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, "R8", "done seen", done, 1);
        chk(mem_cs_n && !mem_sclk, "R8", "cs high at done", {mem_cs_n, mem_sclk}, 2'b10);
        if (!we) chk(rd_data == model(a), "R5", "read byte", rd_data, model(a));
        @(negedge clk);
        chk(!done && !busy, "R8", "done single pulse, idle", {done, busy}, 0);
    endtask

    initial begin
        #(200000 * TCK);
        chk(0, "watchdog", "timeout", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int wait_cyc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_cs_n == 1'b1, "R1", "cs_n in reset", mem_cs_n, 1);
        chk(mem_sclk == 1'b0, "R1", "sclk in reset", mem_sclk, 0);
        chk(mem_dq_oe == 4'h0, "R1", "oe in reset", mem_dq_oe, 0);
        chk(!done && busy, "R1", "done/busy in reset", {done, busy}, 2'b01);
        rst = 1'b0;
        // stray start during power-up (R9)
        req_start = 1'b1; req_addr = 24'hABCDEF;
        wait_cyc = 0;
        while (mem_cs_n && wait_cyc < 10000) begin
            @(negedge clk);
            wait_cyc++;
            if (wait_cyc == 5) req_start = 1'b0;
        end
        chk(wait_cyc >= BOOT && wait_cyc <= BOOT + 3, "R2", "boot quiet cycles", wait_cyc, BOOT);
        while (busy) @(negedge clk);

        xfer(1, 24'h000000, 8'h00, 0);
        xfer(1, 24'hFFFFFF, 8'hFF, 0);
        xfer(1, 24'h5A5A5A, 8'hA5, 0);
        xfer(1, 24'h123456, 8'h7E, 1);
        xfer(0, 24'h000000, 8'h00, 0);
        xfer(0, 24'hFFFFFF, 8'h00, 0);
        xfer(0, 24'h123456, 8'h00, 0);
        xfer(0, 24'hA5C30F, 8'h00, 1);
        xfer(1, 24'h800001, 8'h3C, 0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
        chk(frames == pushed, "R9", "frame count", frames, pushed);
        chk(init_seen, "R3", "mode frame seen", init_seen, 1);
        chk(period_bad == 0, "R6", "sclk period", period_bad, 0);
        chk(stable_bad == 0, "R6", "lanes steady while sclk high", stable_bad, 0);
        chk(idle_bad == 0, "R7", "sclk outside frame", idle_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule